// File: doc/BRIEF.md
# Snooping MSI Cache-Line Controller

This block keeps coherence state for a small direct-mapped, write-back cache that sits on a shared snooping bus with other caching agents. Each line holds a tag and one of three states: Invalid (no data), Shared (a clean, read-only copy) or Exclusive (the only copy, writable and dirty). The processor side presents read and write requests with a block address. The controller answers hits directly. Writes to clean lines are treated as misses. On the bus the controller issues read-miss, write-miss and write-back transactions.

At the same time the controller watches the transactions of the other agents. A foreign read miss or write miss that hits a line lowers that line's state. If the line is dirty, the controller supplies the block and signals that the memory response is to be aborted. The snoop path has its own tag comparison and takes priority over the processor lookup. While a miss waits for bus grant, the line is left untouched. A snooped miss to the same set is handled first, and the processor request is then restarted from a fresh lookup.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset every line is Invalid and the outputs are quiet: `bus_req`=0, `bus_cmd`=00, `cpu_done`=0, `snp_flush`=0. The first access to any address is therefore a miss.
- R2: A read that misses on an Invalid or wrong-tag line issues a read miss (`bus_cmd`=01) carrying the requested block address and the agent's ID. The line then holds the new tag in Shared, so a later read hits and a later write misses.
- R3: A write that misses on an Invalid line issues a write miss (`bus_cmd`=10). The line ends Exclusive, so a later write hits with no bus traffic.
- R4: A write to a line held Shared with a matching tag is handled as a miss. It issues a write miss (10) and moves the line to Exclusive.
- R5: A miss whose line holds a different tag in Exclusive first issues a write-back (`bus_cmd`=11) with the old block address, then issues the read miss or write miss in the very next cycle. The line ends Shared after a read and Exclusive after a write.
- R6: A read hit in Shared or Exclusive, or a write hit in Exclusive, raises `cpu_done` with `cpu_hit`=1 one cycle after the request is accepted. `bus_req` stays low throughout.
- R7: A foreign write miss that hits a Shared line moves the line to Invalid without `snp_flush`.
- R8: A foreign read miss that hits an Exclusive line pulses `snp_flush` in the next cycle and leaves the line Shared. A foreign write miss that hits an Exclusive line pulses `snp_flush` and leaves the line Invalid.
- R9: Snooped transactions that carry the agent's own ID have no effect on any line. Neither do snooped write-back (11) or idle (00) codes.
- R10: Line state is unchanged while a miss waits for grant. A foreign miss to the waiting request's set is applied first. `bus_req` then drops for two cycles, and the request is re-looked-up and re-issued according to the line state as it now stands.
- R11: When a foreign snoop arrives in the same cycle as a processor request in idle, the processor request stalls one cycle. `cpu_done` then comes one cycle later than it would without the snoop.
- R12: A miss raises `cpu_done` with `cpu_hit`=0 in the cycle after its read-miss or write-miss transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Processor block address (low IDX_W bits select the line) |
| cpu_done | output | 1 | Request complete (one cycle) |
| cpu_hit | output | 1 | Completed request was a hit |
| bus_req | output | 1 | Request for the bus, held through the controller's own transactions |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Issued transaction: 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Block address of the issued transaction |
| bus_id | output | ID_W | Requester ID of this agent |
| snp_cmd | input | 2 | Observed bus transaction code, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Observed block address |
| snp_id | input | ID_W | Requester ID of the observed transaction |
| snp_flush | output | 1 | Dirty block supplied by this cache and memory response aborted |

## Verification
A processor hit completes in the first cycle after the accepting edge. A miss shows `bus_req` in that cycle, puts its transaction on the bus one cycle after grant is sampled (two cycles when a write-back comes first), and completes in the following cycle. A snoop's flush is due one cycle after the snoop is presented. Every check samples at the falling edge that follows the rising edge where the result is expected. The bench drives grant and snoops for exactly one cycle, so each sampled value belongs to a single known edge. Line state is observed only through the ports: whether a later access hits, and whether a later snoop flushes.

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 2,
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ID_W-1:0]   bus_id,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              snp_flush
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [ID_W-1:0] MY_ID = ID_W'(AGENT_ID);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2;
  localparam logic [1:0] C_IDLE = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_WB = 2'b11;

  typedef enum logic [2:0] {F_IDLE, F_WAIT, F_WB, F_MISS, F_DONE, F_RETRY} fsm_t;

  fsm_t             fsm;
  logic [1:0]       st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic             rq_we, hit_q, flush_q;
  logic [TAG_W-1:0] rq_tag;
  logic [IDX_W-1:0] rq_idx;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [1:0]       c_st  = st_q[c_idx];
  wire             c_hit = (tag_q[c_idx] == c_tag) && (cpu_we ? (c_st == ST_E) : (c_st != ST_I));

  wire [IDX_W-1:0] s_idx   = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag   = snp_addr[ADDR_W-1:IDX_W];
  wire [1:0]       s_st    = st_q[s_idx];
  wire             s_valid = (snp_cmd == C_RD || snp_cmd == C_WR) && (snp_id != MY_ID);
  wire             s_match = s_valid && (s_st != ST_I) && (tag_q[s_idx] == s_tag);
  wire             s_dirty = s_match && (s_st == ST_E);

  logic [1:0] rq_st;
  assign rq_st = st_q[rq_idx];
  wire need_wb  = (rq_st == ST_E) && (tag_q[rq_idx] != rq_tag);
  wire conflict = s_valid && (s_idx == rq_idx) && (s_match || s_tag == rq_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm     <= F_IDLE;
      rq_we   <= 1'b0;
      rq_tag  <= '0;
      rq_idx  <= '0;
      hit_q   <= 1'b0;
      flush_q <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      flush_q <= s_dirty;
      unique case (fsm)
        F_IDLE:
          if (cpu_req && !s_valid) begin
            rq_we  <= cpu_we;
            rq_tag <= c_tag;
            rq_idx <= c_idx;
            hit_q  <= c_hit;
            fsm    <= c_hit ? F_DONE : F_WAIT;
          end
        F_WAIT:
          if (conflict)     fsm <= F_RETRY;
          else if (bus_gnt) fsm <= need_wb ? F_WB : F_MISS;
        F_WB:   fsm <= F_MISS;
        F_MISS: begin
          st_q[rq_idx]  <= rq_we ? ST_E : ST_S;
          tag_q[rq_idx] <= rq_tag;
          fsm           <= F_DONE;
        end
        F_DONE:  fsm <= F_IDLE;
        F_RETRY: fsm <= F_IDLE;
        default: fsm <= F_IDLE;
      endcase
      if (s_match)
        st_q[s_idx] <= (snp_cmd == C_RD) ? ST_S : ST_I;
    end
  end

  assign bus_req   = (fsm == F_WAIT) || (fsm == F_WB) || (fsm == F_MISS);
  assign bus_cmd   = (fsm == F_WB) ? C_WB : (fsm == F_MISS) ? (rq_we ? C_WR : C_RD) : C_IDLE;
  assign bus_addr  = (fsm == F_WB)   ? {tag_q[rq_idx], rq_idx} :
                     (fsm == F_MISS) ? {rq_tag, rq_idx} : '0;
  assign bus_id    = MY_ID;
  assign cpu_done  = (fsm == F_DONE);
  assign cpu_hit   = cpu_done && hit_q;
  assign snp_flush = flush_q;
endmodule

// File: rtl/snoop_msi_ctrl_chk.sv
module snoop_msi_ctrl_chk #(
  parameter int ID_W     = 2,
  parameter int AGENT_ID = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_req,
  input logic [1:0]      bus_cmd,
  input logic            cpu_done,
  input logic            cpu_hit,
  input logic [1:0]      snp_cmd,
  input logic [ID_W-1:0] snp_id,
  input logic            snp_flush,
  input logic [1:0]      rq_st
);
  wire foreign = (snp_cmd == 2'b01 || snp_cmd == 2'b10) && (snp_id != ID_W'(AGENT_ID));
  wire waiting = bus_req && (bus_cmd == 2'b00);

  AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'b00) |-> bus_req); // R2
  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'b11) |=> (bus_cmd == 2'b01 || bus_cmd == 2'b10)); // R5
  AST_MISS_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'b01 || bus_cmd == 2'b10) |=> (cpu_done && !cpu_hit)); // R12
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_hit) |-> !$past(bus_req)); // R6
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> $past(foreign)); // R8
  AST_OWN_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_id == ID_W'(AGENT_ID)) |=> !snp_flush); // R9
  AST_NO_EARLY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !foreign) |=> $stable(rq_st)); // R10
endmodule

bind snoop_msi_ctrl snoop_msi_ctrl_chk #(.ID_W(ID_W), .AGENT_ID(AGENT_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .cpu_done(cpu_done), .cpu_hit(cpu_hit), .snp_cmd(snp_cmd), .snp_id(snp_id),
  .snp_flush(snp_flush), .rq_st(rq_st)
);

// File: tb/test_snoop_msi_ctrl.sv
module test_snoop_msi_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cpu_req = 1'b0, cpu_we = 1'b0, bus_gnt = 1'b0;
  logic [7:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0, snp_id = '0;
  logic       cpu_done, cpu_hit, bus_req, snp_flush;
  logic [1:0] bus_cmd, bus_id;
  logic [7:0] bus_addr;
  int checks = 0, errors = 0;

  localparam logic [7:0] A = 8'h11, B = 8'h21, C = 8'h31, D = 8'h12;

  always #10 clk = ~clk;

  snoop_msi_ctrl i_snoop_msi_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_id(bus_id), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_id(snp_id), .snp_flush(snp_flush)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_miss(input bit we, input logic [7:0] a, input bit wb, input logic [7:0] wb_a, input string rq);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    if (wb) begin
      chk(bus_cmd, 2'b11, rq, "write-back code");
      chk(bus_addr, wb_a, rq, "write-back address");
      @(negedge clk);
    end
    chk(bus_cmd, we ? 2'b10 : 2'b01, rq, "miss code");
    chk(bus_addr, a, rq, "miss address");
    chk(bus_id, 2'd1, rq, "requester id");
    @(negedge clk);
    chk(cpu_done, 1, rq, "done after miss");
    chk(cpu_hit, 0, rq, "hit flag after miss");
  endtask

  task automatic access(input bit we, input logic [7:0] a, input bit hit, input bit wb, input logic [7:0] wb_a, input string rq);
    cpu_we = we; cpu_addr = a; cpu_req = 1'b1;
    @(negedge clk);
    if (hit) begin
      chk(cpu_done, 1, rq, "done on hit");
      chk(cpu_hit, 1, rq, "hit flag");
      chk(bus_req, 0, rq, "no bus request on hit");
    end else begin
      chk(bus_req, 1, rq, "bus request on miss");
      chk(cpu_done, 0, rq, "not done while waiting");
      finish_miss(we, a, wb, wb_a, rq);
    end
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input logic [1:0] id, input bit flush, input string rq);
    snp_cmd = cmd; snp_addr = a; snp_id = id;
    @(negedge clk);
    snp_cmd = 2'b00;
    chk(snp_flush, flush, rq, "flush pulse");
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(bus_req, 0, "R1", "bus_req after reset");
    chk(bus_cmd, 0, "R1", "bus_cmd after reset");
    chk(cpu_done, 0, "R1", "cpu_done after reset");
    chk(snp_flush, 0, "R1", "snp_flush after reset");
  endtask

  task automatic t_basic;
    access(0, A, 0, 0, 0, "R2");
    access(0, A, 1, 0, 0, "R6");
    access(1, A, 0, 0, 0, "R4");
    access(1, A, 1, 0, 0, "R6");
    access(1, D, 0, 0, 0, "R3");
    access(1, D, 1, 0, 0, "R3");
  endtask

  task automatic t_evict;
    access(0, B, 0, 1, A, "R5");
    access(0, B, 1, 0, 0, "R5");
    access(1, B, 0, 0, 0, "R4");
    access(1, C, 0, 1, B, "R5");
    access(1, C, 1, 0, 0, "R5");
  endtask

  task automatic t_snoop;
    snoop(2'b01, C, 2'd2, 1, "R8");
    access(0, C, 1, 0, 0, "R8");
    snoop(2'b10, C, 2'd2, 0, "R7");
    access(0, C, 0, 0, 0, "R7");
    access(1, C, 0, 0, 0, "R4");
    snoop(2'b10, C, 2'd2, 1, "R8");
    access(0, C, 0, 0, 0, "R8");
  endtask

  task automatic t_ignore;
    access(1, C, 0, 0, 0, "R9");
    snoop(2'b10, C, 2'd1, 0, "R9");
    snoop(2'b11, C, 2'd2, 0, "R9");
    snoop(2'b01, C, 2'd1, 0, "R9");
    access(1, C, 1, 0, 0, "R9");
  endtask

  task automatic t_stall;
    cpu_we = 1'b0; cpu_addr = C; cpu_req = 1'b1;
    snp_cmd = 2'b01; snp_addr = 8'h03; snp_id = 2'd2;
    @(negedge clk);
    snp_cmd = 2'b00;
    chk(cpu_done, 0, "R11", "stalled by snoop");
    @(negedge clk);
    chk(cpu_done, 1, "R11", "done one cycle late");
    chk(cpu_hit, 1, "R11", "hit after stall");
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_conflict;
    cpu_we = 1'b0; cpu_addr = B; cpu_req = 1'b1;
    @(negedge clk);
    chk(bus_req, 1, "R10", "waiting for grant");
    @(negedge clk);
    chk(bus_req, 1, "R10", "still waiting");
    snp_cmd = 2'b01; snp_addr = C; snp_id = 2'd2;
    @(negedge clk);
    snp_cmd = 2'b00;
    chk(snp_flush, 1, "R10", "conflicting snoop served first");
    chk(bus_req, 0, "R10", "request dropped after conflict");
    @(negedge clk);
    chk(bus_req, 0, "R10", "restart lookup cycle");
    @(negedge clk);
    chk(bus_req, 1, "R10", "request re-issued");
    finish_miss(0, B, 0, 0, "R10");
    cpu_req = 1'b0;
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = B; cpu_req = 1'b1;
    @(negedge clk);
    chk(bus_req, 1, "R10", "upgrade waiting");
    snp_cmd = 2'b10; snp_addr = B; snp_id = 2'd3;
    @(negedge clk);
    snp_cmd = 2'b00;
    chk(snp_flush, 0, "R10", "shared copy gives no flush");
    chk(bus_req, 0, "R10", "upgrade dropped");
    @(negedge clk);
    @(negedge clk);
    chk(bus_req, 1, "R10", "upgrade re-issued");
    finish_miss(1, B, 0, 0, "R10");
    cpu_req = 1'b0;
    @(negedge clk);
    access(1, B, 1, 0, 0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_evict();
    t_snoop();
    t_ignore();
    t_stall();
    t_conflict();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule